// File: doc/BRIEF.md
# Field Interrupt Status and Mask Unit

This unit sits on the host side of a video timing generator. It catches single-cycle pulses that mark the start of a top field or a bottom field and holds each one in a sticky status bit until software acknowledges it. A level interrupt line is raised while any held event is also enabled.

Software works through a small word-addressed register port with 32-bit data. Status is read at one address and acknowledged by writing ones to a separate clear address. The enable mask has no plain write address. Software changes it only by writing ones to a set alias or to a clear alias, so two drivers sharing the line never need a read-modify-write. To bring the unit up, software clears 16 status bits and 16 mask bits, then sets the two field bits in the mask.

Top module: `fld_irq_unit`

## Requirements
- R1: While reset is held and after it is released, status reads 0, mask reads 0 and `irq_o` is low.
- R2: A pulse on `ev_bot_i` sets status bit 0 and a pulse on `ev_top_i` sets status bit 1. Status is read at word address 0 and is visible on the cycle after the pulse.
- R3: A write to word address 1 clears exactly the status bits that are 1 in `wdata_i`. Other status bits keep their value.
- R4: If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R5: Writing ones to word address 3 sets those mask bits, and writing ones to word address 2 clears them. Other mask bits keep their value. The mask reads back at address 2 and at address 3.
- R6: Status bits latch whatever the mask holds. Enabling a source whose bit is already set raises the interrupt.
- R7: `irq_o` is the OR of (status AND mask), registered. It reflects the register state one cycle later.
- R8: Data bits above bit 1 have no effect when written and read as 0. Reads of word addresses 4 to 15 return 0.
- R9: The bring-up sequence is: 0xFFFF to address 1, then 0xFFFF to address 2, then 3 to address 3. It leaves status 0, mask 3 and `irq_o` low, whatever state came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_bot_i | input | 1 | Bottom-field event pulse |
| ev_top_i | input | 1 | Top-field event pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every combination of prior status, mask, event pattern and clear pattern for the two field bits. It predicts status and interrupt arithmetically.

The combinations where an event and a clear of the same bit meet in one cycle are the ones aimed at R4. A design in which the clear wins would lose that event and read 0.

Vectors that hold a set status bit under a zero mask catch a design that gates capture with the mask. Such a design would leave the bit unset, and the interrupt would not fire when the mask is enabled later. Writes with all upper data bits high, and reads of unmapped addresses, expose a register that is wider than intended.

Starting the bring-up sequence from a state with everything set shows whether the sequence really returns the unit to a clean state.

// File: rtl/fld_irq_pkg.sv
package fld_irq_pkg;
  localparam int unsigned ADDR_W = 4;

  // word addresses of the register port
  typedef enum logic [ADDR_W-1:0] {
    ADR_STAT     = 4'd0,
    ADR_STAT_CLR = 4'd1,
    ADR_MASK_CLR = 4'd2,
    ADR_MASK_SET = 4'd3
  } reg_addr_e;
endpackage

// File: rtl/fld_irq_rst_sync.sv
module fld_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/fld_irq_status.sv
module fld_irq_status #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] clr_bits_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic st_q, st_d, st_en;

    // an event outranks a clear of the same bit
    always_comb begin
      st_en = ev_i[i] | (clr_en_i & clr_bits_i[i]);
      st_d  = ev_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    st_q <= 1'b0;
      else if (st_en) st_q <= st_d;
    end

    assign status_o[i] = st_q;

    assert_event_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[i] |=> status_o[i]);
    assert_event_beats_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_i[i] && clr_en_i && clr_bits_i[i]) |=> status_o[i]);
    assert_clear_exact_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_i[i] && clr_en_i && clr_bits_i[i]) |=> !status_o[i]);
    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_i[i] && !(clr_en_i && clr_bits_i[i])) |=> $stable(status_o[i]));
  end
endmodule

// File: rtl/fld_irq_mask.sv
module fld_irq_mask #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic               clr_en_i,
  input  logic [NUM_SRC-1:0] bits_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = set_en_i | clr_en_i;
    if (set_en_i) mask_d = mask_q | bits_i;
    else          mask_d = mask_q & ~bits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_set_alias_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((mask_o & $past(bits_i)) == $past(bits_i)));
  assert_clr_alias_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i) |=> ((mask_o & $past(bits_i)) == '0));
  assert_mask_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_en_i || clr_en_i) |=> $stable(mask_o));
endmodule

// File: rtl/fld_irq_out.sv
module fld_irq_out #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               irq_o
);
  logic irq_q, irq_d;

  always_comb irq_d = |(status_i & mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & mask_i)) |=> irq_o);
  assert_irq_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_i & mask_i)) |=> !irq_o);
endmodule

// File: rtl/fld_irq_unit.sv
module fld_irq_unit
  import fld_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_bot_i,
  input  logic              ev_top_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               rst_sync_n;
  logic [NUM_SRC-1:0] ev_vec, status, mask, wbits;
  logic               wr_stclr, wr_mkclr, wr_mkset;
  logic               unused_hi;

  fld_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_sync_n)
  );

  // bit 0 bottom field, bit 1 top field
  always_comb begin
    ev_vec    = '0;
    ev_vec[0] = ev_bot_i;
    ev_vec[1] = ev_top_i;
    wbits     = wdata_i[NUM_SRC-1:0];
    wr_stclr  = wr_en_i && (addr_i == ADR_STAT_CLR);
    wr_mkclr  = wr_en_i && (addr_i == ADR_MASK_CLR);
    wr_mkset  = wr_en_i && (addr_i == ADR_MASK_SET);
  end

  assign unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];

  fld_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .ev_i (ev_vec),
    .clr_en_i (wr_stclr), .clr_bits_i (wbits), .status_o (status)
  );

  fld_irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .set_en_i (wr_mkset),
    .clr_en_i (wr_mkclr), .bits_i (wbits), .mask_o (mask)
  );

  fld_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk_i (clk_i), .rst_ni (rst_sync_n), .status_i (status),
    .mask_i (mask), .irq_o (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      ADR_STAT:                   rdata_o = {{PAD_W{1'b0}}, status};
      ADR_MASK_CLR, ADR_MASK_SET: rdata_o = {{PAD_W{1'b0}}, mask};
      default:                    rdata_o = '0;
    endcase
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_sync_n |=> (status == '0 && mask == '0 && !irq_o));
endmodule

// File: tb/fld_irq_unit_tb_top.sv
module fld_irq_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_bot, ev_top, wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fld_irq_unit dut_i (
    .clk_i (clk), .rst_ni (rst_n), .ev_bot_i (ev_bot), .ev_top_i (ev_top),
    .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; addr = 4'd0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
    addr = 4'd0;
  endtask

  task automatic pulse(logic [1:0] ev);
    ev_bot = ev[0]; ev_top = ev[1];
    tick();
    ev_bot = 1'b0; ev_top = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; ev_bot = 0; ev_top = 0; wr_en = 0; addr = 0; wdata = 0;
    repeat (3) tick();
    rd(4'd0, r); chk("R1 status in reset", r, 0);
    rd(4'd3, r); chk("R1 mask in reset", r, 0);
    chk("R1 irq in reset", {31'b0, irq}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    rd(4'd0, r); chk("R1 status after reset", r, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);

    // R2 / R6: capture with mask zero
    pulse(2'b01); rd(4'd0, r); chk("R2 bottom sets bit0", r, 1);
    pulse(2'b10); rd(4'd0, r); chk("R2 top sets bit1", r, 3);
    tick(); chk("R6 masked, no irq", {31'b0, irq}, 0);
    wr(4'd3, 32'h1); tick();
    chk("R6 enable late fires", {31'b0, irq}, 1);

    // R8: upper bits inert, unmapped reads zero
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd3, 32'hFFFF_FFFC);
    rd(4'd3, r); chk("R8 upper mask bits inert", r, 0);
    rd(4'd2, r); chk("R8 mask clr alias read", r, 0);
    wr(4'd1, 32'hFFFF_FFFC);
    rd(4'd0, r); chk("R8 upper clear bits inert", r, 3);
    for (int a = 4; a < 16; a++) begin
      wr(a[3:0], 32'hFFFF_FFFF);
      rd(a[3:0], r); chk("R8 unmapped read", r, 0);
    end
    rd(4'd0, r); chk("R8 unmapped writes inert", r, 3);

    // R9: bring-up sequence from dirty state
    wr(4'd3, 32'h3);
    wr(4'd1, 32'hFFFF); wr(4'd2, 32'hFFFF); wr(4'd3, 32'h3);
    rd(4'd0, r); chk("R9 status cleared", r, 0);
    rd(4'd3, r); chk("R9 mask enabled", r, 3);
    tick(); chk("R9 irq low", {31'b0, irq}, 0);

    // exhaustive sweep: prior status x mask x events x clear pattern
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 4; e++)
          for (int c = 0; c < 4; c++) begin
            int exp_st;
            wr(4'd1, 32'h3); wr(4'd2, 32'h3);
            pulse(s[1:0]);
            wr(4'd3, m);
            rd(4'd3, r); chk("R5 mask set alias", r, m);
            // one cycle: events plus clear write with upper bits high
            ev_bot = e[0]; ev_top = e[1];
            wr(4'd1, 32'hFFFF_FFFC | c);
            ev_bot = 0; ev_top = 0;
            exp_st = (s & ~c) | e;
            rd(4'd0, r);
            if ((e & c) != 0) chk("R4 event beats clear", r, exp_st);
            else              chk("R3 clear exact bits", r, exp_st);
            tick();
            chk("R7 irq from status and mask", {31'b0, irq},
                ((exp_st & m) != 0) ? 1 : 0);
            wr(4'd2, c);
            rd(4'd2, r); chk("R5 mask clr alias", r, m & ~c);
          end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule